// File: doc/BRIEF.md
# Interleaved Memory Burst Splitter

This block sits where a bus master joins an on-chip network whose memory space is striped across a power-of-two set of memory controllers. Consecutive granules of the address space belong to consecutive controllers. The block accepts one incrementing burst at a time. It cuts the burst into pieces that never straddle a granule edge and tags each piece with its owning controller, a controller-local address and a sequence number. It then issues the pieces one after another on a shared sub-command port.

Responses flow back on two return ports. Read beats may arrive from the controllers in any piece order, and beats of different pieces may interleave. A beat buffer indexed by burst position holds them, and they are released to the master strictly in burst order. Write completions are counted, and a single merged completion carrying the most severe piece code is released once every piece has answered.

A four-state machine runs the block. In `ST_IDLE` it accepts a burst: IDLE to ISSUE on `cmd_valid`. In `ST_ISSUE` it emits pieces: ISSUE to RD_DRAIN on the last read piece, or ISSUE to WR_WAIT on the last write piece. In `ST_RD_DRAIN` it waits for the final read beat to leave: RD_DRAIN to IDLE on the handshake of the beat with `m_rlast`. In `ST_WR_WAIT` it waits for the merged write completion to be taken: WR_WAIT to IDLE on `m_bvalid && m_bready`.

Top module: `ilv_splitter`

## Requirements
- R1: After reset `cmd_ready` is 1 and `sub_valid`, `m_rvalid` and `m_bvalid` are 0.
- R2: `sub_dest` equals address bits [log2(GRAN_BYTES)+log2(NUM_CTRL)-1 : log2(GRAN_BYTES)] of the piece's start address, where NUM_CTRL is 2, 4 or 8.
- R3: Each piece holds min(beats left to the next granule edge, beats still unissued) beats, `sub_len` being beats minus one. No piece crosses a granule edge, and the pieces together cover the burst exactly once in ascending address order.
- R4: A burst lying wholly inside one granule is issued as exactly one piece with `sub_len` equal to `cmd_len`.
- R5: `sub_addr` is the controller-local address: the start address with its controller-index bits removed, the bits above them shifted down by log2(NUM_CTRL) and the granule offset kept.
- R6: `sub_seq` is 0 for the first piece of a burst and grows by one for each further piece.
- R7: Read beats (tagged by `rd_seq`, in order within a piece) leave on `m_rdata`/`m_rresp` in burst address order whatever the piece return order, and `m_rlast` is 1 only on the final beat.
- R8: While `m_rvalid` is 1 and `m_rready` is 0, `m_rvalid`, `m_rdata`, `m_rresp` and `m_rlast` hold.
- R9: For a write burst `m_bvalid` rises only after every piece has returned a `wr_valid` completion. It is then asserted once, with `m_bresp` equal to the numerically largest piece code (OKAY=0, EXOKAY=1, SLVERR=2, DECERR=3).
- R10: `cmd_ready` stays 0 from acceptance of a burst until its last read beat or merged write completion has been handed over.
- R11: While `sub_valid` is 1 and `sub_ready` is 0, the piece fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Burst request valid |
| cmd_ready | output | 1 | Block can accept a burst |
| cmd_write | input | 1 | 1 = write burst, 0 = read burst |
| cmd_addr | input | 64 | Beat-aligned burst start address |
| cmd_len | input | LEN_W | Burst beats minus one |
| sub_valid | output | 1 | Piece valid |
| sub_ready | input | 1 | Piece accepted |
| sub_write | output | 1 | Piece direction |
| sub_dest | output | log2(NUM_CTRL) | Owning controller index |
| sub_addr | output | 64 | Controller-local start address |
| sub_len | output | LEN_W | Piece beats minus one |
| sub_seq | output | SEQ_W | Piece sequence number |
| rd_valid | input | 1 | Returned read beat valid |
| rd_seq | input | SEQ_W | Piece the beat belongs to |
| rd_data | input | DATA_W | Returned read data |
| rd_resp | input | 2 | Returned beat response code |
| wr_valid | input | 1 | Piece write completion valid |
| wr_resp | input | 2 | Piece write completion code |
| m_rvalid | output | 1 | Ordered read beat valid |
| m_rready | input | 1 | Master takes read beat |
| m_rdata | output | DATA_W | Ordered read data |
| m_rresp | output | 2 | Ordered beat response code |
| m_rlast | output | 1 | Final beat of burst |
| m_bvalid | output | 1 | Merged write completion valid |
| m_bready | input | 1 | Master takes write completion |
| m_bresp | output | 2 | Merged write completion code |

## Verification
The bench uses the default parameters: four controllers, a 64-byte granule, 8-byte beats and bursts of up to 16 beats. With eight beats per granule, a burst splits into one, two or three pieces, so unaligned starts, an index wrap from controller 3 back to 0, and a high address with upper bits set all fall within short bursts. Read pieces return in issue order, reversed and beat-interleaved, under ready stalls on both sides. Write pieces return in reverse order with mixed codes so that the severity merge is exercised.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_RD_DRAIN,
        ST_WR_WAIT
    } ilv_state_e;

    localparam logic [1:0] RSP_OKAY   = 2'd0;
    localparam logic [1:0] RSP_EXOKAY = 2'd1;
    localparam logic [1:0] RSP_SLVERR = 2'd2;
    localparam logic [1:0] RSP_DECERR = 2'd3;

    // Severity order matches the numeric order of the codes.
    function automatic logic [1:0] worse_resp(input logic [1:0] a, input logic [1:0] b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ilv_addr_map.sv
module ilv_addr_map #(
    parameter int ADDR_W     = 64,
    parameter int NUM_CTRL   = 4,
    parameter int GRAN_BYTES = 64,
    parameter int BEAT_BYTES = 8,
    parameter int CNT_W      = 5,
    localparam int CTRL_W    = $clog2(NUM_CTRL)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  remain,
    output logic [CTRL_W-1:0] dest,
    output logic [ADDR_W-1:0] local_addr,
    output logic [CNT_W-1:0]  piece_beats,
    output logic              last_piece
);
    localparam int GRAN_SH = $clog2(GRAN_BYTES);
    localparam int BEAT_SH = $clog2(BEAT_BYTES);
    localparam int BPG     = GRAN_BYTES / BEAT_BYTES;

    logic [CNT_W-1:0] room;

    always_comb begin
        room        = CNT_W'(BPG) - CNT_W'(addr[GRAN_SH-1:BEAT_SH]);
        last_piece  = (remain <= room);
        piece_beats = last_piece ? remain : room;
        dest        = addr[GRAN_SH +: CTRL_W];
        local_addr  = {{CTRL_W{1'b0}}, addr[ADDR_W-1:GRAN_SH+CTRL_W], addr[GRAN_SH-1:0]};
    end

endmodule

// File: rtl/ilv_rd_reorder.sv
module ilv_rd_reorder #(
    parameter int DATA_W  = 64,
    parameter int LEN_W   = 4,
    parameter int SEQ_W   = 2,
    localparam int NBEATS = 1 << LEN_W,
    localparam int NSLOT  = 1 << SEQ_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              base_we,
    input  logic [SEQ_W-1:0]  base_seq,
    input  logic [LEN_W-1:0]  base_val,
    input  logic              in_valid,
    input  logic [SEQ_W-1:0]  in_seq,
    input  logic [DATA_W-1:0] in_data,
    input  logic [1:0]        in_resp,
    input  logic [LEN_W-1:0]  last_idx,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [1:0]        out_resp,
    output logic              out_last
);
    logic [LEN_W-1:0]  base_q [NSLOT];
    logic [LEN_W-1:0]  cnt_q  [NSLOT];
    logic [LEN_W-1:0]  head_q;
    logic              vld_q  [NBEATS];
    logic [DATA_W-1:0] data_q [NBEATS];
    logic [1:0]        resp_q [NBEATS];
    logic [LEN_W-1:0]  wr_idx;
    logic              fire;

    assign wr_idx    = base_q[in_seq] + cnt_q[in_seq];
    assign out_valid = vld_q[head_q];
    assign out_data  = data_q[head_q];
    assign out_resp  = resp_q[head_q];
    assign out_last  = (head_q == last_idx);
    assign fire      = out_valid && out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NSLOT; s++) begin
                base_q[s] <= '0;
                cnt_q[s]  <= '0;
            end
        end else if (clear) begin
            for (int s = 0; s < NSLOT; s++) begin
                base_q[s] <= '0;
                cnt_q[s]  <= '0;
            end
        end else begin
            if (base_we)  base_q[base_seq] <= base_val;
            if (in_valid) cnt_q[in_seq]    <= cnt_q[in_seq] + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      head_q <= '0;
        else if (clear)  head_q <= '0;
        else if (fire)   head_q <= head_q + 1'b1;
    end

    for (genvar g = 0; g < NBEATS; g++) begin : g_beat
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                      vld_q[g] <= 1'b0;
            else if (clear)                                  vld_q[g] <= 1'b0;
            else if (in_valid && wr_idx == LEN_W'(g))        vld_q[g] <= 1'b1;
            else if (fire && head_q == LEN_W'(g))            vld_q[g] <= 1'b0;
        end

        always_ff @(posedge clk) begin
            if (in_valid && wr_idx == LEN_W'(g)) begin
                data_q[g] <= in_data;
                resp_q[g] <= in_resp;
            end
        end
    end

endmodule

// File: rtl/ilv_wr_merge.sv
module ilv_wr_merge #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             in_valid,
    input  logic [1:0]       in_resp,
    output logic [CNT_W-1:0] count,
    output logic [1:0]       worst
);
    import ilv_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            worst <= RSP_OKAY;
        end else if (clear) begin
            count <= '0;
            worst <= RSP_OKAY;
        end else if (in_valid) begin
            count <= count + 1'b1;
            worst <= worse_resp(worst, in_resp);
        end
    end

endmodule

// File: rtl/ilv_splitter.sv
module ilv_splitter #(
    parameter int NUM_CTRL   = 4,
    parameter int GRAN_BYTES = 64,
    parameter int BEAT_BYTES = 8,
    parameter int LEN_W      = 4,
    parameter int DATA_W     = 64,
    localparam int ADDR_W     = 64,
    localparam int CTRL_W     = $clog2(NUM_CTRL),
    localparam int BPG        = GRAN_BYTES / BEAT_BYTES,
    localparam int MAX_BEATS  = 1 << LEN_W,
    localparam int MAX_PIECES = (MAX_BEATS + BPG - 1) / BPG + 1,
    localparam int SEQ_W      = $clog2(MAX_PIECES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    output logic              sub_valid,
    input  logic              sub_ready,
    output logic              sub_write,
    output logic [CTRL_W-1:0] sub_dest,
    output logic [ADDR_W-1:0] sub_addr,
    output logic [LEN_W-1:0]  sub_len,
    output logic [SEQ_W-1:0]  sub_seq,
    input  logic              rd_valid,
    input  logic [SEQ_W-1:0]  rd_seq,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [1:0]        rd_resp,
    input  logic              wr_valid,
    input  logic [1:0]        wr_resp,
    output logic              m_rvalid,
    input  logic              m_rready,
    output logic [DATA_W-1:0] m_rdata,
    output logic [1:0]        m_rresp,
    output logic              m_rlast,
    output logic              m_bvalid,
    input  logic              m_bready,
    output logic [1:0]        m_bresp
);
    import ilv_pkg::*;

    localparam int BEAT_SH = $clog2(BEAT_BYTES);
    localparam int LOG_BPG = $clog2(BPG);
    localparam int CNT_W   = ((LEN_W > LOG_BPG) ? LEN_W : LOG_BPG) + 1;
    localparam int PCNT_W  = SEQ_W + 1;

    ilv_state_e        state_q, state_d;
    logic [ADDR_W-1:0] cur_addr_q;
    logic [CNT_W-1:0]  remain_q;
    logic [LEN_W-1:0]  beat_off_q;
    logic [PCNT_W-1:0] seq_cnt_q;
    logic              is_wr_q;
    logic [LEN_W-1:0]  last_idx_q;

    logic [CTRL_W-1:0] map_dest;
    logic [ADDR_W-1:0] map_local;
    logic [CNT_W-1:0]  map_beats;
    logic              map_last;

    logic              accept;
    logic              issue_fire;
    logic              ro_valid;
    logic              ro_last;
    logic              rd_gate;
    logic              rd_done;
    logic [PCNT_W-1:0] wr_count;
    logic [1:0]        wr_worst;

    // Address decomposition for the piece at the current cursor.
    ilv_addr_map #(
        .ADDR_W     (ADDR_W),
        .NUM_CTRL   (NUM_CTRL),
        .GRAN_BYTES (GRAN_BYTES),
        .BEAT_BYTES (BEAT_BYTES),
        .CNT_W      (CNT_W)
    ) u_map (
        .addr        (cur_addr_q),
        .remain      (remain_q),
        .dest        (map_dest),
        .local_addr  (map_local),
        .piece_beats (map_beats),
        .last_piece  (map_last)
    );

    // Read beat reordering by burst position.
    ilv_rd_reorder #(
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W),
        .SEQ_W  (SEQ_W)
    ) u_reorder (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .base_we   (issue_fire),
        .base_seq  (seq_cnt_q[SEQ_W-1:0]),
        .base_val  (beat_off_q),
        .in_valid  (rd_valid),
        .in_seq    (rd_seq),
        .in_data   (rd_data),
        .in_resp   (rd_resp),
        .last_idx  (last_idx_q),
        .out_ready (m_rready && rd_gate),
        .out_valid (ro_valid),
        .out_data  (m_rdata),
        .out_resp  (m_rresp),
        .out_last  (ro_last)
    );

    // Write completion counting and severity merge.
    ilv_wr_merge #(
        .CNT_W (PCNT_W)
    ) u_merge (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .in_valid (wr_valid),
        .in_resp  (wr_resp),
        .count    (wr_count),
        .worst    (wr_worst)
    );

    assign accept     = (state_q == ST_IDLE) && cmd_valid;
    assign issue_fire = (state_q == ST_ISSUE) && sub_ready;
    assign rd_gate    = !is_wr_q && ((state_q == ST_ISSUE) || (state_q == ST_RD_DRAIN));
    assign rd_done    = m_rvalid && m_rready && m_rlast;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (cmd_valid) state_d = ST_ISSUE;
            ST_ISSUE:    if (issue_fire && map_last) state_d = is_wr_q ? ST_WR_WAIT : ST_RD_DRAIN;
            ST_RD_DRAIN: if (rd_done) state_d = ST_IDLE;
            ST_WR_WAIT:  if (m_bvalid && m_bready) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        cmd_ready = (state_q == ST_IDLE);
        sub_valid = (state_q == ST_ISSUE);
        sub_write = is_wr_q;
        sub_dest  = map_dest;
        sub_addr  = map_local;
        sub_len   = LEN_W'(map_beats - 1'b1);
        sub_seq   = seq_cnt_q[SEQ_W-1:0];
        m_rvalid  = ro_valid && rd_gate;
        m_rlast   = ro_last && m_rvalid;
        m_bvalid  = (state_q == ST_WR_WAIT) && (wr_count == seq_cnt_q);
        m_bresp   = wr_worst;
    end

    // Burst cursor.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr_q <= '0;
            remain_q   <= '0;
            beat_off_q <= '0;
            seq_cnt_q  <= '0;
            is_wr_q    <= 1'b0;
            last_idx_q <= '0;
        end else if (accept) begin
            cur_addr_q <= cmd_addr;
            remain_q   <= CNT_W'(cmd_len) + 1'b1;
            beat_off_q <= '0;
            seq_cnt_q  <= '0;
            is_wr_q    <= cmd_write;
            last_idx_q <= cmd_len;
        end else if (issue_fire) begin
            cur_addr_q <= cur_addr_q + (ADDR_W'(map_beats) << BEAT_SH);
            remain_q   <= remain_q - map_beats;
            beat_off_q <= beat_off_q + LEN_W'(map_beats);
            seq_cnt_q  <= seq_cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/ilv_splitter_chk.sv
module ilv_splitter_chk #(
    parameter int GRAN_BYTES = 64,
    parameter int BEAT_BYTES = 8,
    parameter int LEN_W      = 4,
    parameter int DATA_W     = 64,
    parameter int CTRL_W     = 2,
    parameter int SEQ_W      = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_ready,
    input logic              sub_valid,
    input logic              sub_ready,
    input logic [63:0]       sub_addr,
    input logic [LEN_W-1:0]  sub_len,
    input logic [CTRL_W-1:0] sub_dest,
    input logic [SEQ_W-1:0]  sub_seq,
    input logic              m_rvalid,
    input logic              m_rready,
    input logic [DATA_W-1:0] m_rdata,
    input logic              m_rlast,
    input logic              m_bvalid,
    input logic              m_bready
);
    localparam int GRAN_SH = $clog2(GRAN_BYTES);
    localparam int BEAT_SH = $clog2(BEAT_BYTES);
    localparam int BPG     = GRAN_BYTES / BEAT_BYTES;

    AST_PIECE_IN_GRANULE: assert property (@(posedge clk) disable iff (!rst_n)
        sub_valid |-> (int'(sub_addr[GRAN_SH-1:BEAT_SH]) + int'(sub_len)) < BPG); // R3

    AST_SUB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_valid && !sub_ready) |=> (sub_valid && $stable(sub_addr) && $stable(sub_len)
                                       && $stable(sub_dest) && $stable(sub_seq))); // R11

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (m_rvalid && !m_rready) |=> (m_rvalid && $stable(m_rdata) && $stable(m_rlast))); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!sub_valid && !m_rvalid && !m_bvalid)); // R10

    AST_B_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (m_bvalid && m_bready) |=> !m_bvalid); // R9

endmodule

bind ilv_splitter ilv_splitter_chk #(
    .GRAN_BYTES (GRAN_BYTES),
    .BEAT_BYTES (BEAT_BYTES),
    .LEN_W      (LEN_W),
    .DATA_W     (DATA_W),
    .CTRL_W     (CTRL_W),
    .SEQ_W      (SEQ_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_ready (cmd_ready),
    .sub_valid (sub_valid),
    .sub_ready (sub_ready),
    .sub_addr  (sub_addr),
    .sub_len   (sub_len),
    .sub_dest  (sub_dest),
    .sub_seq   (sub_seq),
    .m_rvalid  (m_rvalid),
    .m_rready  (m_rready),
    .m_rdata   (m_rdata),
    .m_rlast   (m_rlast),
    .m_bvalid  (m_bvalid),
    .m_bready  (m_bready)
);

// File: tb/ilv_splitter_bench.sv
module ilv_splitter_bench;

    localparam int NC    = 4;
    localparam int GRAN  = 64;
    localparam int BEAT  = 8;
    localparam int LEN_W = 4;
    localparam int DW    = 64;
    localparam int BPG   = GRAN / BEAT;
    localparam int MAXP  = ((1 << LEN_W) + BPG - 1) / BPG + 1;
    localparam int SEQ_W = $clog2(MAXP);

    typedef struct {
        logic [63:0] addr;
        int          dest;
        int          len;
        int          seq;
    } piece_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic              cmd_ready;
    logic              cmd_write = 1'b0;
    logic [63:0]       cmd_addr = '0;
    logic [LEN_W-1:0]  cmd_len = '0;
    logic              sub_valid;
    logic              sub_ready = 1'b1;
    logic              sub_write;
    logic [1:0]        sub_dest;
    logic [63:0]       sub_addr;
    logic [LEN_W-1:0]  sub_len;
    logic [SEQ_W-1:0]  sub_seq;
    logic              rd_valid = 1'b0;
    logic [SEQ_W-1:0]  rd_seq = '0;
    logic [DW-1:0]     rd_data = '0;
    logic [1:0]        rd_resp = '0;
    logic              wr_valid = 1'b0;
    logic [1:0]        wr_resp = '0;
    logic              m_rvalid;
    logic              m_rready = 1'b1;
    logic [DW-1:0]     m_rdata;
    logic [1:0]        m_rresp;
    logic              m_rlast;
    logic              m_bvalid;
    logic              m_bready = 1'b1;
    logic [1:0]        m_bresp;

    int n_tests = 0;
    int n_fail  = 0;
    int tick    = 0;
    bit stall_en = 1'b0;
    bit busy_tb  = 1'b0;
    bit busy_viol = 1'b0;
    int wr_returned = 0;
    int n_exp_pieces = 0;
    int exp_b = 0;
    bit b_seen = 1'b0;
    bit prev_sub_wait = 1'b0;
    logic [63:0] prev_sub_addr = '0;

    piece_t      exp_sub[$];
    piece_t      got_pieces[$];
    logic [63:0] exp_rdata[$];
    int          exp_rresp[$];
    bit          exp_rlast[$];

    ilv_splitter u_ilv_splitter (
        .clk (clk), .rst_n (rst_n),
        .cmd_valid (cmd_valid), .cmd_ready (cmd_ready), .cmd_write (cmd_write),
        .cmd_addr (cmd_addr), .cmd_len (cmd_len),
        .sub_valid (sub_valid), .sub_ready (sub_ready), .sub_write (sub_write),
        .sub_dest (sub_dest), .sub_addr (sub_addr), .sub_len (sub_len), .sub_seq (sub_seq),
        .rd_valid (rd_valid), .rd_seq (rd_seq), .rd_data (rd_data), .rd_resp (rd_resp),
        .wr_valid (wr_valid), .wr_resp (wr_resp),
        .m_rvalid (m_rvalid), .m_rready (m_rready), .m_rdata (m_rdata),
        .m_rresp (m_rresp), .m_rlast (m_rlast),
        .m_bvalid (m_bvalid), .m_bready (m_bready), .m_bresp (m_bresp)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        tick++;
        #2;
        sub_ready = stall_en ? ((tick % 3) != 0) : 1'b1;
        m_rready  = stall_en ? ((tick % 4) != 1) : 1'b1;
        m_bready  = stall_en ? ((tick % 2) != 0) : 1'b1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] beat_data(input logic [63:0] a);
        return (a * 64'h9E37_79B9) ^ 64'h0F0F_1234_5678_ABCD;
    endfunction

    function automatic int beat_resp(input logic [63:0] a);
        if (a[8:3] == 6'd13) return 2;
        if (a[8:3] == 6'd21) return 3;
        return 0;
    endfunction

    function automatic logic [63:0] global_of(input piece_t p);
        return (p.addr / GRAN) * (GRAN * NC) + 64'(p.dest) * GRAN + (p.addr % GRAN);
    endfunction

    // Reference model: behavioural piece list and read stream.
    task automatic build_model(input logic [63:0] addr, input int len, input bit wr);
        logic [63:0] a;
        int beats;
        int s;
        a = addr;
        beats = len + 1;
        s = 0;
        exp_sub.delete();
        got_pieces.delete();
        while (beats > 0) begin
            piece_t p;
            int off;
            int n;
            off = int'((a % GRAN) / BEAT);
            n = (BPG - off < beats) ? BPG - off : beats;
            p.dest = int'((a / GRAN) % NC);
            p.addr = (a / (GRAN * NC)) * GRAN + (a % GRAN);
            p.len  = n - 1;
            p.seq  = s;
            exp_sub.push_back(p);
            a = a + 64'(n * BEAT);
            beats -= n;
            s++;
        end
        n_exp_pieces = exp_sub.size();
        if (!wr) begin
            for (int i = 0; i <= len; i++) begin
                exp_rdata.push_back(beat_data(addr + 64'(i * BEAT)));
                exp_rresp.push_back(beat_resp(addr + 64'(i * BEAT)));
                exp_rlast.push_back(i == len);
            end
        end
    endtask

    // Cycle monitor, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy_tb && cmd_ready) busy_viol = 1'b1;
            if (prev_sub_wait)
                check(sub_valid && sub_addr == prev_sub_addr, "R11", "piece held under stall",
                      sub_addr, prev_sub_addr);
            prev_sub_wait = sub_valid && !sub_ready;
            prev_sub_addr = sub_addr;
            if (sub_valid && sub_ready) begin
                if (exp_sub.size() == 0) begin
                    check(1'b0, "R3", "unexpected extra piece", sub_addr, 0);
                end else begin
                    piece_t e;
                    piece_t g;
                    e = exp_sub.pop_front();
                    check(int'(sub_dest) == e.dest, "R2", "controller index", sub_dest, e.dest);
                    check(int'(sub_len) == e.len, "R3", "piece length", sub_len, e.len);
                    check(sub_addr == e.addr, "R5", "local address", sub_addr, e.addr);
                    check(int'(sub_seq) == e.seq, "R6", "sequence number", sub_seq, e.seq);
                    g.addr = sub_addr; g.dest = int'(sub_dest);
                    g.len = int'(sub_len); g.seq = int'(sub_seq);
                    got_pieces.push_back(g);
                end
            end
            if (m_rvalid && m_rready) begin
                if (exp_rdata.size() == 0) begin
                    check(1'b0, "R7", "unexpected read beat", m_rdata, 0);
                end else begin
                    logic [63:0] ed;
                    int er;
                    bit el;
                    ed = exp_rdata.pop_front();
                    er = exp_rresp.pop_front();
                    el = exp_rlast.pop_front();
                    check(m_rdata == ed, "R7", "read data order", m_rdata, ed);
                    check(int'(m_rresp) == er, "R7", "read beat code", m_rresp, er);
                    check(m_rlast == el, "R7", "last flag", m_rlast, el);
                    if (el) busy_tb = 1'b0;
                end
            end
            if (m_bvalid && !b_seen)
                check(wr_returned == n_exp_pieces, "R9", "completion before all pieces",
                      wr_returned, n_exp_pieces);
            if (m_bvalid && m_bready) begin
                check(!b_seen, "R9", "second merged completion", 1, 0);
                check(int'(m_bresp) == exp_b, "R9", "merged code", m_bresp, exp_b);
                b_seen = 1'b1;
                busy_tb = 1'b0;
            end
        end
    end

    task automatic issue_cmd(input bit wr, input logic [63:0] addr, input int len);
        cmd_valid = 1'b1;
        cmd_write = wr;
        cmd_addr  = addr;
        cmd_len   = LEN_W'(len);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        @(posedge clk);
        #2;
        cmd_valid = 1'b0;
        busy_tb   = 1'b1;
        busy_viol = 1'b0;
    endtask

    task automatic wait_pieces();
        while (got_pieces.size() < n_exp_pieces) @(posedge clk);
        #2;
    endtask

    // mode 0: issue order, 1: pieces reversed, 2: beats interleaved across pieces
    task automatic drive_reads(input int mode);
        int order[$];
        int np;
        np = got_pieces.size();
        if (mode == 2) begin
            for (int k = 0; k < BPG; k++)
                for (int s = 0; s < np; s++)
                    if (k <= got_pieces[s].len) order.push_back(s * 256 + k);
        end else begin
            for (int i = 0; i < np; i++) begin
                int s;
                s = (mode == 1) ? np - 1 - i : i;
                for (int k = 0; k <= got_pieces[s].len; k++) order.push_back(s * 256 + k);
            end
        end
        foreach (order[i]) begin
            int s;
            int k;
            logic [63:0] ga;
            s = order[i] / 256;
            k = order[i] % 256;
            ga = global_of(got_pieces[s]) + 64'(k * BEAT);
            rd_valid = 1'b1;
            rd_seq   = SEQ_W'(s);
            rd_data  = beat_data(ga);
            rd_resp  = 2'(beat_resp(ga));
            @(posedge clk);
            #2;
            rd_valid = 1'b0;
            if (i % 3 == 1) begin
                @(posedge clk);
                #2;
            end
        end
    endtask

    task automatic run_read(input logic [63:0] addr, input int len, input int mode,
                            input bit stall, input string req);
        stall_en = stall;
        build_model(addr, len, 1'b0);
        issue_cmd(1'b0, addr, len);
        wait_pieces();
        drive_reads(mode);
        while (exp_rdata.size() != 0) @(posedge clk);
        repeat (3) @(posedge clk);
        #2;
        check(exp_sub.size() == 0, req, "all pieces issued", exp_sub.size(), 0);
        check(!busy_viol, "R10", "cmd_ready low while busy", busy_viol, 0);
    endtask

    task automatic run_write(input logic [63:0] addr, input int len, input int c0,
                             input int c1, input int c2, input bit stall, input string req);
        int codes[3];
        codes[0] = c0; codes[1] = c1; codes[2] = c2;
        stall_en = stall;
        b_seen = 1'b0;
        wr_returned = 0;
        build_model(addr, len, 1'b1);
        exp_b = 0;
        for (int s = 0; s < n_exp_pieces; s++) if (codes[s] > exp_b) exp_b = codes[s];
        issue_cmd(1'b1, addr, len);
        wait_pieces();
        for (int s = n_exp_pieces - 1; s >= 0; s--) begin
            wr_valid = 1'b1;
            wr_resp  = 2'(codes[s]);
            @(posedge clk);
            #2;
            wr_valid = 1'b0;
            wr_returned++;
            @(posedge clk);
            #2;
        end
        while (!b_seen) @(posedge clk);
        repeat (3) @(posedge clk);
        #2;
        check(exp_sub.size() == 0, req, "all pieces issued", exp_sub.size(), 0);
        check(b_seen, "R9", "merged completion seen", b_seen, 1);
        check(!busy_viol, "R10", "cmd_ready low while busy", busy_viol, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_ready == 1'b1, "R1", "reset cmd_ready", cmd_ready, 1);
        check(!sub_valid && !m_rvalid && !m_bvalid, "R1", "reset valids",
              {sub_valid, m_rvalid, m_bvalid}, 0);
        @(posedge clk);
        #2;

        run_read(64'h0000_0000_0000_0000, 3, 0, 1'b0, "R4");
        check(got_pieces.size() == 1, "R4", "single-granule piece count", got_pieces.size(), 1);
        run_read(64'h0000_0000_0000_0038, 15, 1, 1'b0, "R3");
        check(got_pieces.size() == 3, "R3", "three pieces for unaligned burst", got_pieces.size(), 3);
        run_read(64'h1234_5678_0000_0F28, 10, 2, 1'b1, "R3");
        run_read(64'h0000_0000_0000_00C0, 15, 1, 1'b1, "R2");
        run_read(64'h0000_0000_0000_0040, 7, 2, 1'b1, "R4");
        run_read(64'hFFFF_0000_0000_0178, 12, 2, 1'b0, "R5");

        run_write(64'h0000_0000_0000_0030, 12, 0, 2, 0, 1'b0, "R3");
        run_write(64'h0000_0000_0000_0080, 7, 1, 0, 0, 1'b1, "R4");
        check(got_pieces.size() == 1, "R4", "single-granule write piece count", got_pieces.size(), 1);
        run_write(64'h0000_0000_0000_0070, 5, 2, 3, 0, 1'b1, "R9");
        run_write(64'h0000_00AB_0000_0108, 14, 0, 0, 0, 1'b0, "R9");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule